// File: doc/BRIEF.md
# Asynchronous SRAM Bus Cycle Controller

This block sits on the host side of an asynchronous static RAM of 128K 16-bit words. It takes single read or write requests from synchronous logic through a valid/ready handshake. It turns each request into a sequence on the memory pins: active-low chip select, write strobe and output enable, a 17-bit address, and a 16-bit data bus. The data bus is split into an output word, a driver enable and an input word, so that the pad ring can build the tri-state buffer. Read data comes back on a one-cycle response strobe.

Every interval of the memory's timing is a parameter in nanoseconds. The controller turns each one into clock cycles by rounding up against the clock period. A write stores data only while chip select and write strobe are both low. The stored word is taken when the first of the two strobes returns high. A parameter picks which strobe frames the write pulse. In the strobe-framed style, chip select is set up first and the write strobe pulses inside it. In the select-framed style, the write strobe is set up first and chip select pulses inside it. Each style has its own recovery and data-hold figures. The controller accepts only one request at a time. It stays busy until the memory cycle and its recovery have both completed.

Top module: `sram_cycle_ctl`

## Requirements
- R1: After reset, and whenever no cycle is in progress, chip select, write strobe and output enable are all high (inactive), the data drivers are off and `req_ready` is 1.
- R2: A read holds chip select and output enable low, with the write strobe high, for the access phase: 11 cycles at the defaults. It then raises chip select and output enable for a turnaround phase before becoming ready again: 5 cycles at the defaults.
- R3: Read data is sampled from `sram_dq_i` at the clock edge that ends the access phase. It is presented on `rsp_rdata` with `rsp_valid` high for exactly one cycle.
- R4: In the strobe-framed write style (`WRITE_BY_WE`=1), chip select falls one cycle before the write strobe. The write strobe stays low for the strobe phase (9 cycles at the defaults) and rises before chip select. Chip select then stays low for the recovery phase (1 cycle at the defaults).
- R5: In the select-framed write style (`WRITE_BY_WE`=0), the write strobe falls one cycle before chip select. Chip select stays low for the strobe phase (9 cycles) and rises before the write strobe. The write strobe then stays low for the recovery phase (2 cycles at the defaults).
- R6: `sram_dq_oe` is 1 from the setup phase to the recovery phase of a write, and at no other time. Output enable stays high throughout a write, so the drivers are never on while output enable is low.
- R7: `sram_addr` changes only on an edge where chip select and write strobe were both high in the cycle before. Address and write data do not change while the write overlap lasts.
- R8: `req_ready` is 0 from the edge that accepts a request until the cycle and its recovery are complete. A `req_valid` pulse while `req_ready` is 0 starts nothing.
- R9: Each phase length is the nanosecond figure divided by the clock period and rounded up. At 8 ns this gives a busy time of 11 cycles for a strobe-framed write, 12 for a select-framed write and 16 for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address of the request |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Controller idle; a request is taken on this edge |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | 17 | Memory address |
| sram_dq_o | output | 16 | Data toward the memory |
| sram_dq_oe | output | 1 | Enable for the data pad drivers |
| sram_dq_i | input | 16 | Data from the memory |

## Verification
The properties assume that reset is held at the start, which puts every memory pin at its inactive level before the first check. They also assume that request fields are looked at only in a cycle where `req_ready` is high. The memory input `sram_dq_i` never enters a property. The stimulus raises `req_valid` for one cycle at a time, on a falling edge and only when both controllers report ready. It also adds a deliberate pulse during a busy write, to show that the pulse is ignored. The memory model behind the pins returns a poison word until the access time has passed, so a sample taken too early shows up as a wrong read value.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_RECOV,
    PH_RD_ACC,
    PH_RD_TURN
  } phase_e;

  // Round a nanosecond figure up to whole clock cycles.
  function automatic int ns_to_cyc(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // Asserted during the last cycle of a phase.
  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_pin_reg.sv
module sram_pin_reg
  import sram_cyc_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 16,
  parameter bit WRITE_BY_WE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic              dq_oe,
  output logic              ready,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_o
);

  logic nxt_ce_n, nxt_we_n, nxt_oe_n, nxt_dq_oe;

  // Pins decoded from the next phase, then registered, so the pads
  // line up with the phase register and carry no decode glitches.
  always_comb begin
    nxt_ce_n  = 1'b1;
    nxt_we_n  = 1'b1;
    nxt_oe_n  = 1'b1;
    nxt_dq_oe = 1'b0;
    case (phase_d)
      PH_SETUP: begin
        nxt_ce_n  = !WRITE_BY_WE;
        nxt_we_n  = WRITE_BY_WE;
        nxt_dq_oe = 1'b1;
      end
      PH_STROBE: begin
        nxt_ce_n  = 1'b0;
        nxt_we_n  = 1'b0;
        nxt_dq_oe = 1'b1;
      end
      PH_RECOV: begin
        nxt_ce_n  = !WRITE_BY_WE;
        nxt_we_n  = WRITE_BY_WE;
        nxt_dq_oe = 1'b1;
      end
      PH_RD_ACC: begin
        nxt_ce_n  = 1'b0;
        nxt_oe_n  = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
      ready <= 1'b1;
      addr  <= '0;
      dq_o  <= '0;
    end else begin
      ce_n  <= nxt_ce_n;
      we_n  <= nxt_we_n;
      oe_n  <= nxt_oe_n;
      dq_oe <= nxt_dq_oe;
      ready <= (phase_d == PH_IDLE);
      if (accept) begin
        addr <= req_addr;
        dq_o <= req_wdata;
      end
    end
  end

endmodule

// File: rtl/sram_cycle_ctl.sv
module sram_cycle_ctl
  import sram_cyc_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 16,
  parameter bit WRITE_BY_WE   = 1'b1,
  parameter int T_WP_NS       = 65,
  parameter int T_AW_NS       = 75,
  parameter int T_DW_NS       = 35,
  parameter int T_WC_NS       = 85,
  parameter int T_WR_WE_NS    = 5,
  parameter int T_WR_CE_NS    = 15,
  parameter int T_DH_WE_NS    = 0,
  parameter int T_DH_CE_NS    = 10,
  parameter int T_AA_NS       = 85,
  parameter int T_ACE_NS      = 85,
  parameter int T_OE_NS       = 45,
  parameter int T_RC_NS       = 85,
  parameter int T_HZ_NS       = 35
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int P       = CLK_PERIOD_NS;
  localparam int C_WP    = ns_to_cyc(T_WP_NS, P);
  localparam int C_AW    = ns_to_cyc(T_AW_NS, P);
  localparam int C_DW    = ns_to_cyc(T_DW_NS, P);
  localparam int C_WC    = ns_to_cyc(T_WC_NS, P);
  localparam int C_WR    = ns_to_cyc(WRITE_BY_WE ? T_WR_WE_NS : T_WR_CE_NS, P);
  localparam int C_DH    = ns_to_cyc(WRITE_BY_WE ? T_DH_WE_NS : T_DH_CE_NS, P);
  localparam int C_ACC   = imax(imax(ns_to_cyc(T_AA_NS, P), ns_to_cyc(T_ACE_NS, P)),
                                ns_to_cyc(T_OE_NS, P));
  localparam int C_RC    = ns_to_cyc(T_RC_NS, P);
  localparam int C_HZ    = ns_to_cyc(T_HZ_NS, P);

  // One setup cycle precedes the strobe; address is valid from there on.
  localparam int N_STROBE = imax(imax(imax(C_WP, C_AW - 1), C_DW), 1);
  localparam int N_RECOV  = imax(imax(imax(C_WR, C_DH), C_WC - 1 - N_STROBE), 1);
  localparam int N_ACC    = imax(C_ACC, 1);
  localparam int N_TURN   = imax(imax(C_HZ, C_RC - N_ACC), 1);
  localparam int N_MAX    = imax(imax(N_STROBE, N_RECOV), imax(N_ACC, N_TURN));
  localparam int CNT_W    = $clog2(N_MAX + 1);

  localparam logic [CNT_W-1:0] L_SETUP  = '0;
  localparam logic [CNT_W-1:0] L_STROBE = CNT_W'(N_STROBE - 1);
  localparam logic [CNT_W-1:0] L_RECOV  = CNT_W'(N_RECOV - 1);
  localparam logic [CNT_W-1:0] L_ACC    = CNT_W'(N_ACC - 1);
  localparam logic [CNT_W-1:0] L_TURN   = CNT_W'(N_TURN - 1);

  phase_e           phase_q, phase_d;
  logic             accept, capture, tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  assign accept = req_valid && (phase_q == PH_IDLE);

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    case (phase_q)
      PH_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (req_write) begin
          phase_d = PH_SETUP;
          tmr_val = L_SETUP;
        end else begin
          phase_d = PH_RD_ACC;
          tmr_val = L_ACC;
        end
      end
      PH_SETUP: if (tmr_done) begin
        phase_d  = PH_STROBE;
        tmr_load = 1'b1;
        tmr_val  = L_STROBE;
      end
      PH_STROBE: if (tmr_done) begin
        phase_d  = PH_RECOV;
        tmr_load = 1'b1;
        tmr_val  = L_RECOV;
      end
      PH_RECOV: if (tmr_done) phase_d = PH_IDLE;
      PH_RD_ACC: if (tmr_done) begin
        capture  = 1'b1;
        phase_d  = PH_RD_TURN;
        tmr_load = 1'b1;
        tmr_val  = L_TURN;
      end
      PH_RD_TURN: if (tmr_done) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  sram_pin_reg #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .WRITE_BY_WE (WRITE_BY_WE)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .phase_d   (phase_d),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ce_n      (sram_ce_n),
    .we_n      (sram_we_n),
    .oe_n      (sram_oe_n),
    .dq_oe     (sram_dq_oe),
    .ready     (req_ready),
    .addr      (sram_addr),
    .dq_o      (sram_dq_o)
  );

  // Read data taken on the edge that closes the access phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= sram_dq_i;
    end
  end

endmodule

// File: rtl/sram_cycle_ctl_chk.sv
module sram_cycle_ctl_chk #(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 16,
  parameter bit WRITE_BY_WE = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_dq_o
);

  AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe)); // R1

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> !sram_dq_oe); // R6

  AST_OVERLAP_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && !sram_we_n) |-> (sram_dq_oe && sram_oe_n)); // R6

  AST_ADDR_MOVES_SAFE: assert property (@(posedge clk) disable iff (rst)
    !$stable(sram_addr) |-> ($past(sram_ce_n) && $past(sram_we_n))); // R7

  AST_OVERLAP_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && !sram_we_n && $past(!sram_ce_n && !sram_we_n))
      |-> ($stable(sram_addr) && $stable(sram_dq_o))); // R7

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R3

  AST_BUSY_AT_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready); // R8

  generate
    if (WRITE_BY_WE) begin : g_we_style
      AST_WE_FALLS_LAST: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_we_n) |-> $past(!sram_ce_n)); // R4
      AST_WE_RISES_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_ce_n) |-> $past(sram_we_n)); // R4
    end else begin : g_ce_style
      AST_CE_FALLS_LAST: assert property (@(posedge clk) disable iff (rst)
        ($fell(sram_ce_n) && !sram_we_n) |-> $past(!sram_we_n)); // R5
      AST_CE_RISES_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> $past(sram_ce_n)); // R5
    end
  endgenerate

endmodule

bind sram_cycle_ctl sram_cycle_ctl_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .WRITE_BY_WE (WRITE_BY_WE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .sram_ce_n  (sram_ce_n),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_dq_oe (sram_dq_oe),
  .sram_addr  (sram_addr),
  .sram_dq_o  (sram_dq_o)
);

// File: tb/sram_cycle_ctl_tb.sv
module sram_beh_mem #(
  parameter int VALID_AFTER = 10
) (
  input  logic        clk,
  input  logic        ce_n,
  input  logic        we_n,
  input  logic        oe_n,
  input  logic [16:0] addr,
  input  logic [15:0] dq_o,
  input  logic        dq_oe,
  output logic [15:0] dq_i
);
  logic [15:0] store [int];
  logic        was_ov = 1'b0;
  int          rd_age = 0;
  logic [15:0] word;

  always @(posedge clk) begin
    logic ov;
    ov = !ce_n && !we_n;
    if (was_ov && !ov) store[int'(addr)] = dq_oe ? dq_o : 16'hEEEE;
    was_ov = ov;
    if (!ce_n && !oe_n && we_n) rd_age <= rd_age + 1;
    else                        rd_age <= 0;
  end

  always @* begin
    if (store.exists(int'(addr))) word = store[int'(addr)];
    else                          word = addr[15:0] ^ 16'h5A5A;
  end

  assign dq_i = (rd_age >= VALID_AFTER) ? word : 16'hBAD0;
endmodule

module sram_cycle_ctl_tb;
  localparam int PER = 8;

  function automatic int cdiv(input int ns);
    return (ns + PER - 1) / PER;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int STROBE = mx(mx(cdiv(65), cdiv(75) - 1), cdiv(35));
  localparam int REC_WE = mx(mx(cdiv(5), cdiv(0)), mx(cdiv(85) - 1 - STROBE, 1));
  localparam int REC_CE = mx(mx(cdiv(15), cdiv(10)), mx(cdiv(85) - 1 - STROBE, 1));
  localparam int ACC    = mx(mx(cdiv(85), cdiv(85)), cdiv(45));
  localparam int TURN   = mx(cdiv(35), mx(cdiv(85) - ACC, 1));
  localparam int LEN_RD = ACC + TURN;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr  = '0;
  logic [15:0] req_wdata = '0;

  logic        rdy   [2];
  logic        rv    [2];
  logic [15:0] rdata [2];
  logic        ce_n  [2];
  logic        we_n  [2];
  logic        oe_n  [2];
  logic [16:0] addr  [2];
  logic [15:0] dqo   [2];
  logic        dqoe  [2];
  logic [15:0] dqi   [2];

  int vectors = 0;
  int fails   = 0;
  bit cmp_en  = 1'b0;

  always #4 clk = ~clk;

  sram_cycle_ctl #(.CLK_PERIOD_NS(PER), .WRITE_BY_WE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(rdy[0]),
    .rsp_valid(rv[0]), .rsp_rdata(rdata[0]), .sram_ce_n(ce_n[0]),
    .sram_we_n(we_n[0]), .sram_oe_n(oe_n[0]), .sram_addr(addr[0]),
    .sram_dq_o(dqo[0]), .sram_dq_oe(dqoe[0]), .sram_dq_i(dqi[0]));

  sram_cycle_ctl #(.CLK_PERIOD_NS(PER), .WRITE_BY_WE(1'b0)) u_dut_ce (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(rdy[1]),
    .rsp_valid(rv[1]), .rsp_rdata(rdata[1]), .sram_ce_n(ce_n[1]),
    .sram_we_n(we_n[1]), .sram_oe_n(oe_n[1]), .sram_addr(addr[1]),
    .sram_dq_o(dqo[1]), .sram_dq_oe(dqoe[1]), .sram_dq_i(dqi[1]));

  sram_beh_mem #(.VALID_AFTER(ACC - 1)) u_mem_we (
    .clk(clk), .ce_n(ce_n[0]), .we_n(we_n[0]), .oe_n(oe_n[0]), .addr(addr[0]),
    .dq_o(dqo[0]), .dq_oe(dqoe[0]), .dq_i(dqi[0]));
  sram_beh_mem #(.VALID_AFTER(ACC - 1)) u_mem_ce (
    .clk(clk), .ce_n(ce_n[1]), .we_n(we_n[1]), .oe_n(oe_n[1]), .addr(addr[1]),
    .dq_o(dqo[1]), .dq_oe(dqoe[1]), .dq_i(dqi[1]));

  // Reference model: position inside the current cycle per instance.
  logic [15:0] ref_mem [int];
  bit          m_busy [2];
  bit          m_wr   [2];
  int          m_n    [2];
  int          m_len  [2];
  logic [16:0] m_addr [2];
  logic [15:0] m_data [2];
  logic [15:0] m_exp  [2];
  int          low_cnt [2];

  function automatic logic [15:0] ref_word(input logic [16:0] a);
    if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
    return a[15:0] ^ 16'h5A5A;
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (rst) m_busy[i] = 1'b0;
      else if (m_busy[i]) begin
        m_n[i] = m_n[i] + 1;
        if (m_n[i] == m_len[i]) m_busy[i] = 1'b0;
      end else if (req_valid) begin
        m_busy[i] = 1'b1;
        m_n[i]    = 0;
        m_wr[i]   = req_write;
        m_addr[i] = req_addr;
        m_data[i] = req_wdata;
        m_exp[i]  = ref_word(req_addr);
        m_len[i]  = req_write ? (1 + STROBE + (i == 0 ? REC_WE : REC_CE)) : LEN_RD;
      end
    end
    if (!rst && req_valid && req_write && !m_busy[0]) ref_mem[int'(req_addr)] = req_wdata;
    if (!rst && req_valid && req_write && m_busy[0] && m_n[0] == 0)
      ref_mem[int'(req_addr)] = req_wdata;
  end

  task automatic chk(input string tag, input string what, input int i,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s inst%0d t=%0t: actual %h expected %h", tag, what, i, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      for (int i = 0; i < 2; i++) begin
        logic e_ce, e_we, e_oe, e_oe_drv, e_rdy, e_rv;
        string t;
        int    rec;
        rec = (i == 0) ? REC_WE : REC_CE;
        e_ce = 1; e_we = 1; e_oe = 1; e_oe_drv = 0; e_rdy = 1; e_rv = 0; t = "R1";
        if (m_busy[i]) begin
          e_rdy = 0;
          if (m_wr[i]) begin
            t = (i == 0) ? "R4" : "R5";
            e_oe_drv = 1;
            if (m_n[i] == 0) begin e_ce = (i == 1); e_we = (i == 0); end
            else if (m_n[i] <= STROBE) begin e_ce = 0; e_we = 0; end
            else begin e_ce = (i == 1); e_we = (i == 0); end
          end else begin
            t = "R2";
            if (m_n[i] < ACC) begin e_ce = 0; e_oe = 0; end
            e_rv = (m_n[i] == ACC);
          end
        end else if (m_len[i] > 0 && !m_wr[i] && m_n[i] == ACC && LEN_RD == ACC) begin
          e_rv = 1;
        end
        chk(t, "ce_n", i, 32'(ce_n[i]), 32'(e_ce));
        chk(t, "we_n", i, 32'(we_n[i]), 32'(e_we));
        chk(t, "oe_n", i, 32'(oe_n[i]), 32'(e_oe));
        chk("R6", "dq_oe", i, 32'(dqoe[i]), 32'(e_oe_drv));
        chk("R8", "ready", i, 32'(rdy[i]), 32'(e_rdy));
        chk("R3", "rsp_valid", i, 32'(rv[i]), 32'(e_rv));
        if (e_rv) chk("R3", "rsp_rdata", i, 32'(rdata[i]), 32'(m_exp[i]));
        if (m_busy[i]) chk("R7", "addr", i, 32'(addr[i]), 32'(m_addr[i]));
        if (m_busy[i] && m_wr[i]) chk("R7", "dq_o", i, 32'(dqo[i]), 32'(m_data[i]));
        if (!rdy[i]) low_cnt[i]++;
        else if (low_cnt[i] > 0) begin
          chk("R9", "busy length", i, 32'(low_cnt[i]), 32'(m_len[i]));
          low_cnt[i] = 0;
        end
      end
    end
  end

  task automatic op(input bit wr, input logic [16:0] a, input logic [15:0] d);
    while (!(rdy[0] && rdy[1])) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (!(rdy[0] && rdy[1])) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_busy[i] = 0; m_n[i] = 0; m_len[i] = 0; m_wr[i] = 0; low_cnt[i] = 0;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    for (int i = 0; i < 2; i++) begin
      chk("R1", "reset ce_n", i, 32'(ce_n[i]), 32'd1);
      chk("R1", "reset dq_oe", i, 32'(dqoe[i]), 32'd0);
      chk("R1", "reset ready", i, 32'(rdy[i]), 32'd1);
    end
    cmp_en = 1'b1;
    // Boundary addresses and data patterns (R4, R5, R3)
    op(1'b1, 17'h00000, 16'h0000);
    op(1'b1, 17'h1FFFF, 16'hFFFF);
    op(1'b0, 17'h00000, 16'h0);
    op(1'b0, 17'h1FFFF, 16'h0);
    // Unwritten location
    op(1'b0, 17'h00005, 16'h0);
    // R8: request while busy must start nothing
    op(1'b1, 17'h00123, 16'hA5C3);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h0BEEF;
    @(negedge clk);
    req_valid = 1'b0;
    op(1'b0, 17'h00123, 16'h0);
    // Read immediately followed by write (turnaround, R2, R6)
    op(1'b0, 17'h10000, 16'h0);
    op(1'b1, 17'h10000, 16'h1234);
    op(1'b0, 17'h10000, 16'h0);
    // Mixed traffic over a small address set
    for (int k = 0; k < 40; k++) begin
      logic [31:0] r;
      r = $urandom;
      op(r[0], {14'h0, r[3:1]}, r[31:16]);
    end
    settle();
    cmp_en = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule